// File: doc/BRIEF.md
# Dual Prescaled PWM Generator

This block produces two pulse-width modulated outputs from a byte-wide register bus. Each channel takes a clock source (the system clock undivided, the system clock divided by 4, 16 or 64, or the rising edges of an external PWM clock pin). A frequency divider then slows that source by a programmable factor N+1 and produces the count enable for an 8-bit pulse counter. The pin goes high when the counter wraps to zero and drops when the counter reaches the channel's compare value. The duty cycle is therefore compare/256.

Software can load a new compare value at any time. While the channel runs, the value waits in a pending register until the next wrap, so a period is never cut short. A per-channel select bit sends the value address to the live counter instead, so the counter can be preset and read back. A force bit holds the pin at 1, and clearing the output enable parks the pin at 1. A mode bit joins the two channels into one 16-bit PWM. The first channel's value register is the low byte and the second channel's value register is the high byte. The joined PWM uses the first channel's clock path, enable and pin.

Each channel has a small state machine with three states. PH_OFF means the clock path is stopped. PH_HIGH means the pin is in the asserted part of the period. PH_LOW means the pin is in the released part. The transitions are:
- START: PH_OFF to PH_HIGH or PH_LOW, when the clock path is enabled.
- MATCH: PH_HIGH to PH_LOW, when the count reaches the compare value.
- ROLL: PH_LOW to PH_HIGH, when the count wraps.
- STOP: any state to PH_OFF, when the clock enable is cleared.

Top module: `pwm_pair`

## Requirements
- R1: Address map on `bus_addr`:
  - 0 is channel 0 control and 1 is channel 1 control.
  - 2 and 3 are the frequency values N for channel 0 and channel 1.
  - 4 and 5 are the value registers for channel 0 and channel 1.
  - 6 is the mode/flag byte, with bit0 = joined 16-bit mode, bit1 = channel 0 flag and bit2 = channel 1 flag.
  - In a control byte, bits 2:0 are the source select, bit3 is the clock enable, bit4 is the output enable, bit5 is the force-high bit and bit6 is the counter-access select. Bit 7 reads 0.
- R2: After reset every register reads 0 and both pins are 1. Source codes 000, 001, 010 and 011 advance the clock path once every 1, 4, 16 and 64 system clocks.
- R3: A source code with bit 2 set takes one source event per rising edge of `ext_pwm_clk`.
- R4: The frequency divider passes one count per N+1 source events.
- R5: The counter advances by one per divided event and wraps from FFh to 00h. The wrap sets the channel's flag. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged.
- R6: While the channel runs, the pin is 1 exactly while the count is below the active compare value, so over a period it is high for compare of every 256 counts. A stopped channel with output enabled and force clear drives 0.
- R7: A compare written while the channel runs becomes active at the next wrap. A compare written while the channel is stopped is active at once.
- R8: With the select bit clear, the value address writes and reads the pending compare. With the select bit set, it writes and reads the live counter.
- R9: Clearing the clock enable stops counting, and the counter holds its value.
- R10: With the output enable clear, the pin is 1.
- R11: The force bit drives the pin to 1 in 8-bit mode and has no effect in joined mode.
- R12: In joined mode the counter is {channel 1 count, channel 0 count} and the compare is {channel 1 value, channel 0 value}. The pair runs on channel 0's clock path, enable and output enable, and channel 1's clock bits have no effect. Channel 1's pin is held at 1, and channel 0's flag is set on the 16-bit wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ext_pwm_clk | input | 1 | External PWM clock pin |
| pwm_out | output | 2 | PWM pins, one per channel |

## Verification
The hardest case to reach from the ports is the deferred compare update. A new compare value must be written while the counter is in a known running position, and the old value must then be seen to stay in force until the wrap. The stimulus presets the counter through the select bit while the channel is stopped, then starts the clock with N=0 so each cycle is one count. The new compare is written a fixed two cycles later. The pin is then sampled at the same count before and after the wrap. The joined mode is reached the same way: the 16-bit counter is preset just below the carry and the wrap, and then run for exactly two cycles.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    typedef enum logic [2:0] {
        A_CTL0 = 3'd0,
        A_CTL1 = 3'd1,
        A_FRQ0 = 3'd2,
        A_FRQ1 = 3'd3,
        A_VAL0 = 3'd4,
        A_VAL1 = 3'd5,
        A_MODE = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic       sel_cnt;
        logic       dc_force;
        logic       out_en;
        logic       clk_on;
        logic [2:0] src;
    } chan_ctl_t;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

endpackage

// File: rtl/pwm_clk_gen.sv
module pwm_clk_gen #(
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [2:0]    src,
    input  logic [DW-1:0] div_n,
    input  logic          ext_clk,
    output logic          tick
);
    localparam int PRE_W = 6;

    logic [SYNC-1:0]  sync_q;
    logic             ext_prev_q;
    logic [PRE_W-1:0] pre_q;
    logic [DW-1:0]    div_q;
    logic             ext_rise;
    logic             src_tick;

    assign ext_rise = sync_q[SYNC-1] & ~ext_prev_q;

    always_comb begin
        if (!en) begin
            src_tick = 1'b0;
        end else if (src[2]) begin
            src_tick = ext_rise;
        end else begin
            unique case (src[1:0])
                2'd0:    src_tick = 1'b1;
                2'd1:    src_tick = &pre_q[1:0];
                2'd2:    src_tick = &pre_q[3:0];
                default: src_tick = &pre_q[5:0];
            endcase
        end
    end

    assign tick = src_tick && (div_q == div_n);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q     <= '0;
            ext_prev_q <= 1'b0;
            pre_q      <= '0;
            div_q      <= '0;
        end else begin
            sync_q     <= {sync_q[SYNC-2:0], ext_clk};
            ext_prev_q <= sync_q[SYNC-1];
            pre_q      <= en ? pre_q + 1'b1 : '0;
            if (!en) begin
                div_q <= '0;
            end else if (src_tick) begin
                div_q <= (div_q == div_n) ? '0 : div_q + 1'b1;
            end
        end
    end

    // R9: no counting pulse while the clock path is off
    p_idle_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick);

    // R4: with N above zero, two counting pulses are never adjacent
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_n != '0) |=> (!tick || !$stable(div_n)));

endmodule

// File: rtl/pwm_pulse_core.sv
module pwm_pulse_core
    import pwm_pair_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wide,
    input  logic [1:0]         tick,
    input  logic [1:0]         clk_on,
    input  logic [1:0]         out_en,
    input  logic [1:0]         dc_force,
    input  logic [1:0]         cnt_wr,
    input  logic [1:0]         cmp_wr,
    input  logic [1:0]         flag_clr,
    input  logic [DW-1:0]      wdata,
    output logic [1:0][DW-1:0] cnt_o,
    output logic [1:0][DW-1:0] pend_o,
    output logic [1:0]         flag_o,
    output logic [1:0]         pin_o
);
    localparam logic [DW-1:0] TOP = '1;

    logic [1:0][DW-1:0] cnt_q, cnt_d, pend_q, pend_d, act_q, act_d;
    logic [1:0]         flag_q;
    logic [1:0]         run, adv, wrap, load_act, set_flag, lvl;
    logic               roll16, lvl_w;

    always_comb begin
        run[0] = clk_on[0];
        run[1] = wide ? clk_on[0] : clk_on[1];
        adv[0] = tick[0];
        adv[1] = wide ? (tick[0] && cnt_q[0] == TOP) : tick[1];
        for (int i = 0; i < 2; i++) begin
            wrap[i] = adv[i] && (cnt_q[i] == TOP);
        end
        roll16      = wide && wrap[0] && wrap[1];
        set_flag[0] = wide ? roll16 : wrap[0];
        set_flag[1] = !wide && wrap[1];
        for (int i = 0; i < 2; i++) begin
            load_act[i] = !run[i] || (wide ? roll16 : wrap[i]);
            cnt_d[i]    = cnt_wr[i] ? wdata : (adv[i] ? cnt_q[i] + 1'b1 : cnt_q[i]);
            pend_d[i]   = cmp_wr[i] ? wdata : pend_q[i];
            act_d[i]    = load_act[i] ? pend_d[i] : act_q[i];
            lvl[i]      = cnt_d[i] < act_d[i];
        end
        lvl_w = {cnt_d[1], cnt_d[0]} < {act_d[1], act_d[0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= '0;
            act_q  <= '0;
            flag_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
            act_q  <= act_d;
            flag_q <= (flag_q & ~flag_clr) | set_flag;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_ch
        phase_e ph_q, ph_d;
        logic   hi;

        assign hi = (g == 0 && wide) ? lvl_w : lvl[g];

        always_comb begin
            unique case (ph_q)
                PH_OFF:  ph_d = !run[g] ? PH_OFF : (hi ? PH_HIGH : PH_LOW);  // START
                PH_HIGH: ph_d = !run[g] ? PH_OFF : (hi ? PH_HIGH : PH_LOW);  // MATCH / STOP
                PH_LOW:  ph_d = !run[g] ? PH_OFF : (hi ? PH_HIGH : PH_LOW);  // ROLL / STOP
                default: ph_d = PH_OFF;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ph_q <= PH_OFF;
            else        ph_q <= ph_d;
        end

        assign pin_o[g] = !out_en[g] | (dc_force[g] & !wide) | ((g == 1) && wide)
                        | (ph_q == PH_HIGH);

        // R6: the asserted phase only exists while the count is below the compare
        p_high_below_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ph_q == PH_HIGH && !wide && !$past(wide)) |-> (cnt_q[g] < act_q[g]));
    end

    assign cnt_o  = cnt_q;
    assign pend_o = pend_q;
    assign flag_o = flag_q;

    // R5: a wrap always leaves the flag set
    p_roll_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag[0] |=> flag_q[0]);

    // R9: a stopped channel holds its count unless software loads it
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[0] && !cnt_wr[0]) |=> $stable(cnt_q[0]));

    // R11: force bit drives channel 0 high in 8-bit mode
    p_dc_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_force[0] && !wide) |-> pin_o[0]);

    // R12: second pin parked high in joined mode
    p_wide_pin1_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wide |-> pin_o[1]);

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
    import pwm_pair_pkg::*;
#(
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ext_pwm_clk,
    output logic [1:0]    pwm_out
);
    localparam int CTL_W = $bits(chan_ctl_t);

    chan_ctl_t          ctl_q [2];
    logic [1:0][DW-1:0] frq_q;
    logic               wide_q;
    logic [1:0]         tick, clk_on, out_en, dc_force, cnt_wr, cmp_wr, flag_clr, flag;
    logic [1:0][DW-1:0] cnt, pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q[0] <= '0;
            ctl_q[1] <= '0;
            frq_q    <= '0;
            wide_q   <= 1'b0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_CTL0:  ctl_q[0] <= chan_ctl_t'(bus_wdata[CTL_W-1:0]);
                A_CTL1:  ctl_q[1] <= chan_ctl_t'(bus_wdata[CTL_W-1:0]);
                A_FRQ0:  frq_q[0] <= bus_wdata;
                A_FRQ1:  frq_q[1] <= bus_wdata;
                A_MODE:  wide_q   <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_path
        logic en_path;
        assign en_path     = (g == 0) ? ctl_q[0].clk_on : (ctl_q[1].clk_on && !wide_q);
        assign clk_on[g]   = ctl_q[g].clk_on;
        assign out_en[g]   = ctl_q[g].out_en;
        assign dc_force[g] = ctl_q[g].dc_force;
        assign cnt_wr[g]   = bus_wr && (bus_addr == 3'(A_VAL0 + g)) && ctl_q[g].sel_cnt;
        assign cmp_wr[g]   = bus_wr && (bus_addr == 3'(A_VAL0 + g)) && !ctl_q[g].sel_cnt;
        assign flag_clr[g] = bus_wr && (bus_addr == A_MODE) && !bus_wdata[1+g];

        pwm_clk_gen #(.DW(DW), .SYNC(SYNC)) u_clk (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_path),
            .src     (ctl_q[g].src),
            .div_n   (frq_q[g]),
            .ext_clk (ext_pwm_clk),
            .tick    (tick[g])
        );
    end

    pwm_pulse_core #(.DW(DW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (wide_q),
        .tick     (tick),
        .clk_on   (clk_on),
        .out_en   (out_en),
        .dc_force (dc_force),
        .cnt_wr   (cnt_wr),
        .cmp_wr   (cmp_wr),
        .flag_clr (flag_clr),
        .wdata    (bus_wdata),
        .cnt_o    (cnt),
        .pend_o   (pend),
        .flag_o   (flag),
        .pin_o    (pwm_out)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTL0:  bus_rdata = DW'(ctl_q[0]);
            A_CTL1:  bus_rdata = DW'(ctl_q[1]);
            A_FRQ0:  bus_rdata = frq_q[0];
            A_FRQ1:  bus_rdata = frq_q[1];
            A_VAL0:  bus_rdata = ctl_q[0].sel_cnt ? cnt[0] : pend[0];
            A_VAL1:  bus_rdata = ctl_q[1].sel_cnt ? cnt[1] : pend[1];
            A_MODE:  bus_rdata = DW'({flag, wide_q});
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: tb/pwm_pair_tb.sv
`timescale 1ns/1ps
module pwm_pair_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_pwm_clk = 1'b0;
    logic [1:0] pwm_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    string q_req[$];
    int    q_got[$];
    int    q_exp[$];

    always #4 clk = ~clk;

    pwm_pair u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ext_pwm_clk (ext_pwm_clk),
        .pwm_out     (pwm_out)
    );

    // driver side: push an observed/expected pair for the monitor
    task automatic expect_item(input string req, input int got, input int exp);
        q_req.push_back(req);
        q_got.push_back(got);
        q_exp.push_back(exp);
    endtask

    // monitor: pops items and scores them
    always @(posedge clk) begin
        while (q_req.size() > 0) begin
            string r;
            int    g;
            int    e;
            r = q_req.pop_front();
            g = q_got.pop_front();
            e = q_exp.pop_front();
            total++;
            if (g != e) begin
                bad++;
                $display("FAIL %s actual=%0d expected=%0d", r, g, e);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic count_high(input int ch, input int n, output int h);
        h = 0;
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
            h += int'(pwm_out[ch]);
        end
    endtask

    task automatic rate_check(input string req, input logic [7:0] ctl, input logic [7:0] n,
                              input int window, input int exp);
        int a;
        int b;
        wr(3'd0, 8'h50);
        wr(3'd2, n);
        wr(3'd0, ctl);
        idle(10);
        rd(3'd4, a);
        idle(window);
        rd(3'd4, b);
        expect_item(req, (b - a) & 8'hFF, exp);
    endtask

    task automatic finish_run();
        wait (q_req.size() == 0);
        @(posedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        int v1;
        int h;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2: reset values of every register and both pins
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            expect_item($sformatf("R2 reset reg %0d", a), v, 0);
        end
        expect_item("R2 R10 reset pins", int'(pwm_out), 3);

        // R8: compare path vs counter path
        wr(3'd0, 8'h10);
        wr(3'd4, 8'd64);
        rd(3'd4, v);
        expect_item("R8 pending compare readback", v, 64);
        wr(3'd0, 8'h50);
        wr(3'd4, 8'd0);
        rd(3'd4, v);
        expect_item("R8 counter readback", v, 0);
        expect_item("R6 stopped pin low", int'(pwm_out[0]), 0);

        // R6: duty over one full period
        wr(3'd0, 8'h58);
        count_high(0, 256, h);
        expect_item("R6 duty 64/256", h, 64);
        rd(3'd4, v);
        expect_item("R5 wrap to zero", v, 0);
        rd(3'd6, v);
        expect_item("R5 flag set on wrap", v, 2);
        wr(3'd6, 8'h00);
        rd(3'd6, v);
        expect_item("R5 flag cleared by 0", v, 0);

        // R9: hold when stopped
        wr(3'd0, 8'h50);
        rd(3'd4, v);
        idle(50);
        rd(3'd4, v1);
        expect_item("R9 counter holds", v1, v);

        // R2: undivided source, one count per cycle
        wr(3'd4, 8'd0);
        wr(3'd0, 8'h58);
        idle(10);
        rd(3'd4, v);
        expect_item("R2 R5 code 000 one per clock", v, 10);

        // R2, R4: prescaler codes and frequency divider
        rate_check("R4 code000 N=3", 8'h58, 8'd3, 400, 100);
        rate_check("R2 R4 code001 N=2", 8'h59, 8'd2, 1200, 100);
        rate_check("R2 code010 N=0", 8'h5A, 8'd0, 1600, 100);
        rate_check("R2 code011 N=0", 8'h5B, 8'd0, 6400, 100);

        // R3: external clock edges
        wr(3'd0, 8'h50);
        wr(3'd2, 8'd0);
        wr(3'd0, 8'h5C);
        idle(5);
        rd(3'd4, v);
        for (int k = 0; k < 50; k++) begin
            ext_pwm_clk = 1'b1;
            idle(3);
            ext_pwm_clk = 1'b0;
            idle(3);
        end
        idle(4);
        rd(3'd4, v1);
        expect_item("R3 external edges", (v1 - v) & 8'hFF, 50);

        // R7: deferred compare
        wr(3'd0, 8'h50);
        wr(3'd4, 8'd0);
        wr(3'd0, 8'h10);
        wr(3'd4, 8'd50);
        wr(3'd0, 8'h50);
        wr(3'd4, 8'd0);
        wr(3'd0, 8'h58);
        wr(3'd0, 8'h18);
        wr(3'd4, 8'd200);
        idle(148);
        expect_item("R7 old compare before wrap", int'(pwm_out[0]), 0);
        rd(3'd4, v);
        expect_item("R8 pending holds new value", v, 200);
        idle(256);
        expect_item("R7 new compare after wrap", int'(pwm_out[0]), 1);
        wr(3'd6, 8'h02);
        rd(3'd6, v);
        expect_item("R5 writing 1 keeps flag", v & 2, 2);

        // R10, R11, R6
        wr(3'd0, 8'h10);
        wr(3'd0, 8'h00);
        expect_item("R10 output disabled pin high", int'(pwm_out[0]), 1);
        wr(3'd0, 8'h30);
        expect_item("R11 force while stopped", int'(pwm_out[0]), 1);
        wr(3'd4, 8'd0);
        wr(3'd0, 8'h38);
        count_high(0, 20, h);
        expect_item("R11 force with compare 0", h, 20);
        wr(3'd0, 8'h18);
        count_high(0, 20, h);
        expect_item("R6 compare 0 never high", h, 0);

        // R8 on the second channel
        wr(3'd1, 8'h40);
        wr(3'd5, 8'd7);
        rd(3'd5, v);
        expect_item("R8 channel 1 counter", v, 7);

        // R12: joined mode carry and wrap
        wr(3'd0, 8'h50);
        wr(3'd6, 8'h01);
        wr(3'd1, 8'h48);
        wr(3'd4, 8'hFE);
        wr(3'd5, 8'h05);
        wr(3'd0, 8'h58);
        idle(1);
        wr(3'd0, 8'h50);
        rd(3'd4, v);
        expect_item("R12 low byte after carry", v, 0);
        rd(3'd5, v);
        expect_item("R12 high byte after carry", v, 6);
        rd(3'd6, v);
        expect_item("R12 no flag without 16-bit wrap", v, 1);
        wr(3'd4, 8'hFE);
        wr(3'd5, 8'hFF);
        wr(3'd0, 8'h58);
        idle(1);
        wr(3'd0, 8'h50);
        rd(3'd5, v);
        expect_item("R12 16-bit wrap high byte", v, 0);
        rd(3'd6, v);
        expect_item("R12 flag on 16-bit wrap", v, 3);

        // R12, R11: joined duty with force ignored
        wr(3'd0, 8'h10);
        wr(3'd1, 8'h08);
        wr(3'd4, 8'h80);
        wr(3'd5, 8'h01);
        wr(3'd0, 8'h50);
        wr(3'd1, 8'h58);
        wr(3'd4, 8'h70);
        wr(3'd5, 8'h01);
        wr(3'd0, 8'h78);
        count_high(0, 40, h);
        expect_item("R12 R11 joined duty, force ignored", h, 15);
        expect_item("R12 second pin parked", int'(pwm_out[1]), 1);

        done = 1'b1;
        finish_run();
    end

endmodule